// File: doc/BRIEF.md
# GPIO Controller with Interrupts

This block is a register-mapped controller for up to 32 general-purpose pins. A simple 32-bit register bus with a word index, a write strobe, a read strobe and combinational read data gives software per-pin control. Each pin is either handed to an alternate-function port or driven from the software registers. Under software control the pin has its own direction, drive-enable and output value.

Pin inputs pass through a two-stage synchronizer before software reads them and before they feed event detection. Each pin has its own detector, set for level or edge sensing with a chosen polarity, or for both edges. Detected events latch into a status word. A single interrupt line is raised from the status bits whose mask bit is clear. Reading the status word returns it and clears it in the same access. The mask changes only through write-one-to-enable and write-one-to-disable registers.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is in bypass and in input mode, drive-enables and output values are zero, every pin is masked, the status word is zero and `irq` is low.
- R2: Registers sit at word indices: 0 bypass, 1 direction, 2 drive-enable, 3 output value, 4 input value, 5 mask, 6 unmask, 7 mask-set, 8 status, 9 detect mode, 10 polarity, 11 both-edge. Registers 0–3 and 9–11 read back the last value written, so the output value register returns what was written and not the pin level.
- R3: Bits at or above `NPINS` read as zero and ignore writes.
- R4: A bypass bit of 1 takes the pin's `pin_out` and `pin_oe` from `alt_out` and `alt_oe`. A bypass bit of 0 takes them from the output value and drive-enable registers.
- R5: For a pin not in bypass, a direction bit of 1 (input) forces `pin_oe` low whatever its drive-enable bit holds. A direction bit of 0 passes the drive-enable bit through.
- R6: Writing 1 to a bit of index 6 clears that mask bit. Writing 1 to a bit of index 7 sets it. Zero bits change nothing, and writes to index 5 are ignored.
- R7: The input value register shows `pin_in` after two clock edges through a two-flop synchronizer.
- R8: A detect-mode bit of 1 selects level sensing: polarity 1 means active-high, 0 means active-low. A level that is still active sets the status bit again in the cycle after a clearing read.
- R9: A detect-mode bit of 0 selects edge sensing. A both-edge bit of 1 fires on either edge; otherwise polarity 1 selects rising edges and 0 selects falling edges.
- R10: A read of index 8 returns the latched status and clears it. An event detected in the same cycle as that read stays latched. Status bits never drop without a read.
- R11: `irq` is high when any status bit with a clear mask bit is set. It responds directly to mask changes and to status clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Pin input levels, asynchronous |
| alt_out | input | NPINS | Alternate-function output values |
| alt_oe | input | NPINS | Alternate-function drive-enables |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin drive-enables |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an edge that the detector registers in exactly the cycle a status read clears the word. If the design handles it wrongly, the event is lost without trace. The bench counts the synchronizer and edge-register stages from the pin change. It raises the read strobe so that it covers the third clock edge after the change. The read then returns the old word, and a second read must show the new bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_BYPASS = 4'd0,
        RA_DIR    = 4'd1,
        RA_OE     = 4'd2,
        RA_OUT    = 4'd3,
        RA_IN     = 4'd4,
        RA_MASK   = 4'd5,
        RA_UNMASK = 4'd6,
        RA_MSET   = 4'd7,
        RA_STAT   = 4'd8,
        RA_MODE   = 4'd9,
        RA_POL    = 4'd10,
        RA_BOTH   = 4'd11
    } reg_addr_e;

    // Per-pin event detector configuration
    typedef struct packed {
        logic level;   // 1: level sense, 0: edge sense
        logic pol;     // 1: high / rising, 0: low / falling
        logic both;    // edge sense on either edge
    } det_cfg_t;

    function automatic logic pin_event(det_cfg_t cfg, logic cur, logic prev);
        logic hit;
        if (cfg.level)
            hit = cfg.pol ? cur : ~cur;
        else if (cfg.both)
            hit = cur ^ prev;
        else if (cfg.pol)
            hit = cur & ~prev;
        else
            hit = ~cur & prev;
        return hit;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [W-1:0]      byp_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      oe_q,
    output logic [W-1:0]      outv_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      mode_q,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      both_q
);
    logic [W-1:0] wd;
    assign wd = wr_data[W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q  <= '1;
            dir_q  <= '1;
            oe_q   <= '0;
            outv_q <= '0;
            mask_q <= '1;
            mode_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_BYPASS: byp_q  <= wd;
                RA_DIR:    dir_q  <= wd;
                RA_OE:     oe_q   <= wd;
                RA_OUT:    outv_q <= wd;
                RA_UNMASK: mask_q <= mask_q & ~wd;
                RA_MSET:   mask_q <= mask_q | wd;
                RA_MODE:   mode_q <= wd;
                RA_POL:    pol_q  <= wd;
                RA_BOTH:   both_q <= wd;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_in,
    input  logic [W-1:0] mode_cfg,
    input  logic [W-1:0] pol_cfg,
    input  logic [W-1:0] both_cfg,
    input  logic         clr_stat,
    output logic [W-1:0] evt,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_pin
        det_cfg_t cfg;
        assign cfg    = '{level: mode_cfg[i], pol: pol_cfg[i], both: both_cfg[i]};
        assign evt[i] = pin_event(cfg, lvl_in[i], prev_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= lvl_in;
            stat_q <= (clr_stat ? '0 : stat_q) | evt;
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] byp_q, dir_q, oe_q, outv_q, mask_q;
    logic [NPINS-1:0] mode_q, pol_q, both_q;
    logic [NPINS-1:0] in_sync, evt, stat_q;
    logic             stat_rd;

    assign stat_rd = bus_rd && (bus_addr == RA_STAT);

    gpio_reg_file #(.W(NPINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .byp_q   (byp_q),
        .dir_q   (dir_q),
        .oe_q    (oe_q),
        .outv_q  (outv_q),
        .mask_q  (mask_q),
        .mode_q  (mode_q),
        .pol_q   (pol_q),
        .both_q  (both_q)
    );

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .d_sync  (in_sync)
    );

    gpio_irq_detect #(.W(NPINS)) u_det (
        .clk      (clk),
        .rst      (rst),
        .lvl_in   (in_sync),
        .mode_cfg (mode_q),
        .pol_cfg  (pol_q),
        .both_cfg (both_q),
        .clr_stat (stat_rd),
        .evt      (evt),
        .stat_q   (stat_q)
    );

    // Per-pin output steering
    for (genvar i = 0; i < NPINS; i++) begin : g_pad
        always_comb begin
            if (byp_q[i]) begin
                pin_out[i] = alt_out[i];
                pin_oe[i]  = alt_oe[i];
            end else begin
                pin_out[i] = outv_q[i];
                pin_oe[i]  = oe_q[i] & ~dir_q[i];
            end
        end
    end

    assign irq = |(stat_q & ~mask_q);

    always_comb begin
        case (bus_addr)
            RA_BYPASS: bus_rdata = 32'(byp_q);
            RA_DIR:    bus_rdata = 32'(dir_q);
            RA_OE:     bus_rdata = 32'(oe_q);
            RA_OUT:    bus_rdata = 32'(outv_q);
            RA_IN:     bus_rdata = 32'(in_sync);
            RA_MASK:   bus_rdata = 32'(mask_q);
            RA_STAT:   bus_rdata = 32'(stat_q);
            RA_MODE:   bus_rdata = 32'(mode_q);
            RA_POL:    bus_rdata = 32'(pol_q);
            RA_BOTH:   bus_rdata = 32'(both_q);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [31:0]      bus_wdata,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] stat_q,
    input logic [NPINS-1:0] evt,
    input logic [NPINS-1:0] byp_q,
    input logic [NPINS-1:0] dir_q
);
    // R6
    unmask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_UNMASK) |=> ((mask_q & $past(bus_wdata[NPINS-1:0])) == '0));

    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_MSET) |=> ((~mask_q & $past(bus_wdata[NPINS-1:0])) == '0));

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == RA_UNMASK || bus_addr == RA_MSET)) |=> $stable(mask_q));

    // R10
    stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == RA_STAT) |=> ((stat_q & ~$past(evt)) == '0));

    // R10
    stat_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_addr == RA_STAT) |=> (($past(stat_q) & ~stat_q) == '0));

    // R5
    oe_input_chk: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & ~byp_q & dir_q) == '0));

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |-> !irq);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .evt       (evt),
    .byp_q     (byp_q),
    .dir_q     (dir_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
    localparam int N = 20;
    localparam logic [31:0] ALL = 32'h000F_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  alt_out = '0;
    logic [N-1:0]  alt_oe = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(N)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_stat();
        logic [31:0] d;
        settle();
        rd(4'd8, d);
        rd(4'd8, d);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d); chk("R1 bypass", d, ALL);
        rd(4'd1, d); chk("R1 direction", d, ALL);
        rd(4'd2, d); chk("R1 drive-enable", d, 0);
        rd(4'd3, d); chk("R1 output value", d, 0);
        rd(4'd5, d); chk("R1 mask", d, ALL);
        rd(4'd8, d); chk("R1 status", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(4'd0, 0); wr(4'd1, 0); wr(4'd2, ALL);
        pin_in = 20'h0F0F0;
        wr(4'd3, 32'h000A_5A5A);
        settle();
        rd(4'd3, d); chk("R2 output value readback", d, 32'h000A_5A5A);
        chk("R2 pin_out follows register", 32'(pin_out), 32'h000A_5A5A);
        wr(4'd9, 32'h0001_2345); rd(4'd9, d); chk("R2 mode readback", d, 32'h0001_2345);
        wr(4'd10, 32'h000C_0FFE); rd(4'd10, d); chk("R2 polarity readback", d, 32'h000C_0FFE);
        wr(4'd11, 32'h0003_0303); rd(4'd11, d); chk("R2 both-edge readback", d, 32'h0003_0303);
        wr(4'd4, 32'h0); rd(4'd4, d); chk("R2 input reg ignores write", d, 32'h0000_F0F0);
        wr(4'd9, 0); wr(4'd10, 0); wr(4'd11, 0);
        pin_in = '0;
    endtask

    task automatic t_upper();
        logic [31:0] d;
        wr(4'd3, 32'hFFF0_0123); rd(4'd3, d); chk("R3 upper bits zero", d, 32'h0000_0123);
        wr(4'd9, 32'hFFFF_FFFF); rd(4'd9, d); chk("R3 upper bits mode", d, ALL);
        wr(4'd9, 0);
    endtask

    task automatic t_bypass();
        wr(4'd0, 32'h0000_000F); wr(4'd1, 0); wr(4'd2, ALL);
        wr(4'd3, 32'h0005_5555);
        alt_out = 20'hAAAAA; alt_oe = 20'h00005;
        #1;
        chk("R4 mixed pin_out", 32'(pin_out), 32'h0005_555A);
        chk("R4 mixed pin_oe", 32'(pin_oe), 32'h000F_FFF5);
        alt_oe = '0;
    endtask

    task automatic t_oe_dir();
        wr(4'd0, 0); wr(4'd2, ALL); wr(4'd1, 32'h0000_00FF);
        #1 chk("R5 inputs not driven", 32'(pin_oe), 32'h000F_FF00);
        wr(4'd1, 0); wr(4'd2, 32'h0000_F0F0);
        #1 chk("R5 drive-enable passes", 32'(pin_oe), 32'h0000_F0F0);
        wr(4'd1, ALL);
        #1 chk("R5 all input", 32'(pin_oe), 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(4'd6, 32'h0000_0003); rd(4'd5, d); chk("R6 unmask clears", d, 32'h000F_FFFC);
        wr(4'd6, 0);             rd(4'd5, d); chk("R6 zero unmask no effect", d, 32'h000F_FFFC);
        wr(4'd7, 32'h0000_0001); rd(4'd5, d); chk("R6 mask-set sets", d, 32'h000F_FFFD);
        wr(4'd7, 0);             rd(4'd5, d); chk("R6 zero mask-set no effect", d, 32'h000F_FFFD);
        wr(4'd5, 0);             rd(4'd5, d); chk("R6 mask read-only", d, 32'h000F_FFFD);
        wr(4'd7, ALL);
    endtask

    task automatic t_sync();
        @(negedge clk);
        bus_addr = 4'd4;
        pin_in = 20'h3C3C3;
        @(posedge clk); #1 chk("R7 one edge old", bus_rdata, 0);
        @(posedge clk); #1 chk("R7 two edges new", bus_rdata, 32'h0003_C3C3);
        @(negedge clk); pin_in = '0;
        clear_stat();
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(4'd9, 32'h20); wr(4'd10, 32'h20);
        clear_stat();
        @(negedge clk) pin_in[5] = 1'b1;
        settle();
        rd(4'd8, d); chk("R8 active-high latched", d, 32'h20);
        rd(4'd8, d); chk("R8 level persists after read", d, 32'h20);
        @(negedge clk) pin_in[5] = 1'b0;
        settle();
        rd(4'd8, d); rd(4'd8, d); chk("R8 inactive high level", d, 0);
        wr(4'd10, 0);
        settle();
        rd(4'd8, d); chk("R8 active-low latched", d, 32'h20);
        wr(4'd9, 0);
        clear_stat();
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(4'd10, 32'h80);
        clear_stat();
        @(negedge clk) pin_in[7] = 1'b1; settle();
        rd(4'd8, d); chk("R9 rising fires", d, 32'h80);
        rd(4'd8, d); chk("R10 read cleared", d, 0);
        @(negedge clk) pin_in[7] = 1'b0; settle();
        rd(4'd8, d); chk("R9 rising ignores fall", d, 0);
        wr(4'd10, 0);
        @(negedge clk) pin_in[7] = 1'b1; settle();
        rd(4'd8, d); chk("R9 falling ignores rise", d, 0);
        @(negedge clk) pin_in[7] = 1'b0; settle();
        rd(4'd8, d); chk("R9 falling fires", d, 32'h80);
        wr(4'd11, 32'h80);
        @(negedge clk) pin_in[7] = 1'b1; settle();
        rd(4'd8, d); chk("R9 both-edge rise", d, 32'h80);
        @(negedge clk) pin_in[7] = 1'b0; settle();
        rd(4'd8, d); chk("R9 both-edge fall", d, 32'h80);
        wr(4'd11, 0);
    endtask

    task automatic t_coincident();
        logic [31:0] d;
        wr(4'd10, 32'h100);
        clear_stat();
        @(negedge clk) pin_in[8] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 4'd8; bus_rd = 1'b1;
        #1 chk("R10 coincident read old", bus_rdata, 0);
        @(negedge clk) bus_rd = 1'b0;
        rd(4'd8, d); chk("R10 coincident event kept", d, 32'h100);
        wr(4'd10, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(4'd10, 32'h200);
        clear_stat();
        @(negedge clk) pin_in[9] = 1'b1; settle();
        chk("R11 masked no irq", {31'd0, irq}, 0);
        wr(4'd6, 32'h200);
        #1 chk("R11 unmask raises irq", {31'd0, irq}, 1);
        wr(4'd7, 32'h200);
        #1 chk("R11 mask drops irq", {31'd0, irq}, 0);
        wr(4'd6, 32'h200);
        rd(4'd8, d);
        #1 chk("R11 read drops irq", {31'd0, irq}, 0);
        chk("R10 read value", d, 32'h200);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_upper();
        t_bypass();
        t_oe_dir();
        t_mask();
        t_sync();
        t_level();
        t_edge();
        t_coincident();
        t_irq();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule